// File: doc/BRIEF.md
# Prioritized Restart-Opcode Interrupt Responder

This block collects up to eight peripheral interrupt requests and presents them to a processor that has one maskable interrupt input and an active-low acknowledge strobe. A low-to-high transition on a request line is captured as a pending request. While anything is pending, the block holds its interrupt output high. When the processor acknowledges, the block drops the interrupt output and returns one opcode byte, which the processor executes as a one-byte call instruction. The byte is a restart opcode whose three-bit field holds the index of the highest-numbered pending request. A restart index n corresponds to a call to address 8*n.

The opcode is presented on a data port with a companion drive-enable. The chip-level pad logic uses the enable to switch the tri-state bus buffer. The index is frozen at the start of the acknowledge, so the returned byte cannot change while the strobe is low. When the acknowledge ends, the serviced request is cleared. Other requests stay pending and raise the interrupt output again. All inputs are assumed synchronous to `clk`.

Top module: `irq_restart_responder`

## Requirements
- R1: The returned index is the highest-numbered pending request. Index 7 has the top priority and index 0 the lowest.
- R2: The returned byte is {2'b11, n[2:0], 3'b111}, with n in bits 5:3. Index 0 gives C7h, index 2 gives D7h, index 5 gives EFh and index 7 gives FFh.
- R3: `bus_drive_o` is 1 in the cycle after each clock edge at which `inta_n` is sampled low, and 0 otherwise. Whenever `bus_drive_o` is 0, `bus_data_o` is 00h.
- R4: A request becomes pending when its line is sampled low at one edge and high at the next edge. It stays pending until it is serviced. A line that is held high after being serviced is not captured again.
- R5: `intr_o` is registered. It is 1 when any request is pending. It is forced to 0 in the cycle after every edge at which `inta_n` is sampled low.
- R6: The index is latched at the first edge at which `inta_n` is sampled low. The byte holds that value until `inta_n` returns high, even if a higher-priority request arrives in the meantime.
- R7: At the edge where `inta_n` is first sampled high again, the serviced request is cleared. Other pending requests keep `intr_o` at 1 from the next cycle. A new rising edge on the serviced line at that same edge stays pending.
- R8: If an acknowledge starts while nothing is pending, the block returns C7h and clears no request.
- R9: A synchronous active-high `rst` clears all pending requests and drives `intr_o`, `bus_drive_o` and `bus_data_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Peripheral request lines; bit i is request index i |
| inta_n | input | 1 | Active-low interrupt acknowledge from the processor |
| intr_o | output | 1 | Interrupt request to the processor |
| bus_data_o | output | 8 | Restart opcode for the data bus, 00h when not driving |
| bus_drive_o | output | 1 | Enable for the tri-state data-bus buffer |

## Verification
The assertions check the following on every cycle:
- the winning index has no higher pending bit above it;
- every driven byte has the fixed restart form;
- the byte is held steady for the whole acknowledge;
- the bus reads 00h when not driving;
- the interrupt output falls after a sampled acknowledge;
- each rising request becomes pending.

Only the bench scenarios can show the following:
- that the serviced request, and only that one, is cleared;
- that other requests bring the interrupt back;
- that a held-high line is not recaptured;
- that an empty acknowledge returns C7h and leaves new requests intact.

A reference model checks all outputs every cycle against random request and acknowledge traffic.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

  // Width of the restart index field inside the opcode
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned MAX_REQ = 1 << IDX_W;
  localparam int unsigned BYTE_W  = 8;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // One-byte restart opcode: two ones, the index, three ones
  function automatic byte_t restart_opcode(input idx_t n);
    return {2'b11, n, 3'b111};
  endfunction

endpackage

// File: rtl/req_capture.sv
module req_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] pend_next_o
);

  logic [N-1:0] req_q;
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic rise;
    assign rise           = req_i[i] & ~req_q[i];
    // A fresh rising edge wins over a clear on the same edge
    assign pend_next_o[i] = (pend_q[i] & ~clr_mask[i]) | rise;

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        req_q[i]  <= req_i[i];
        pend_q[i] <= pend_next_o[i];
      end
    end

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
      (req_i[i] && !req_q[i]) |=> pend_q[i]);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  // Ascending scan: the last set bit, which is the highest index, wins
  always_comb begin
    idx_o = '0;
    any_o = |vec_i;
    for (int k = 0; k < N; k++) begin
      if (vec_i[k]) idx_o = IW'(k);
    end
  end

  always_comb begin
    if (any_o) begin
      p_winner_r1: assert ((vec_i >> idx_o) == {{(N-1){1'b0}}, 1'b1});
    end
  end

endmodule

// File: rtl/ack_sequencer.sv
module ack_sequencer
  import irq_resp_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inta_n,
  input  idx_t         win_idx,
  input  logic         win_any,
  output logic [N-1:0] clr_mask,
  output logic         drive_o,
  output byte_t        data_o
);

  logic  ack_prev_n;
  idx_t  lat_idx;
  logic  lat_v;
  logic  drive_q;
  byte_t data_q;
  logic  ack_fall;
  logic  ack_rise;

  assign ack_fall = ~inta_n & ack_prev_n;
  assign ack_rise = inta_n & ~ack_prev_n;
  assign clr_mask = (ack_rise && lat_v) ? ({{(N-1){1'b0}}, 1'b1} << lat_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_prev_n <= 1'b1;
      lat_idx    <= '0;
      lat_v      <= 1'b0;
      drive_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      ack_prev_n <= inta_n;
      drive_q    <= ~inta_n;
      if (ack_fall) begin
        lat_idx <= win_idx;
        lat_v   <= win_any;
        data_q  <= restart_opcode(win_idx);
      end else if (inta_n) begin
        data_q  <= '0;
      end
    end
  end

  assign drive_o = drive_q;
  assign data_o  = data_q;

  p_opcode_form_r2: assert property (@(posedge clk) disable iff (rst)
    drive_q |-> (data_q[7:6] == 2'b11 && data_q[2:0] == 3'b111));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (drive_q && $past(drive_q)) |-> $stable(data_q));

  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    !drive_q |-> (data_q == '0));

endmodule

// File: rtl/irq_restart_responder.sv
module irq_restart_responder
  import irq_resp_pkg::*;
#(
  parameter int unsigned NUM_REQ = MAX_REQ
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               inta_n,
  output logic               intr_o,
  output logic [BYTE_W-1:0]  bus_data_o,
  output logic               bus_drive_o
);

  logic [NUM_REQ-1:0] pend;
  logic [NUM_REQ-1:0] pend_next;
  logic [NUM_REQ-1:0] clr_mask;
  idx_t               win_idx;
  logic               win_any;
  logic               intr_q;

  req_capture #(.N(NUM_REQ)) u_capture (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .clr_mask    (clr_mask),
    .pend_o      (pend),
    .pend_next_o (pend_next)
  );

  prio_pick #(.N(NUM_REQ), .IW(IDX_W)) u_pick (
    .vec_i (pend),
    .idx_o (win_idx),
    .any_o (win_any)
  );

  ack_sequencer #(.N(NUM_REQ)) u_ack (
    .clk      (clk),
    .rst      (rst),
    .inta_n   (inta_n),
    .win_idx  (win_idx),
    .win_any  (win_any),
    .clr_mask (clr_mask),
    .drive_o  (bus_drive_o),
    .data_o   (bus_data_o)
  );

  // Request to the processor is withheld while acknowledge is low
  always_ff @(posedge clk) begin
    if (rst) intr_q <= 1'b0;
    else     intr_q <= inta_n & (|pend_next);
  end

  assign intr_o = intr_q;

  p_intr_drop_r5: assert property (@(posedge clk) disable iff (rst)
    !inta_n |=> !intr_o);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!intr_o && !bus_drive_o && bus_data_o == '0));

endmodule

// File: tb/tb_irq_restart_responder.sv
module tb_irq_restart_responder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_i = '0;
  logic       inta_n = 1'b1;
  logic       intr_o;
  logic [7:0] bus_data_o;
  logic       bus_drive_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference-model state
  logic [7:0] m_pend, m_reqprev, m_data;
  logic       m_inta_prev, m_intr, m_drive, m_latv;
  logic [2:0] m_lat;

  always #10 clk = ~clk;

  irq_restart_responder dut (
    .clk(clk), .rst(rst), .req_i(req_i), .inta_n(inta_n),
    .intr_o(intr_o), .bus_data_o(bus_data_o), .bus_drive_o(bus_drive_o)
  );

  function automatic logic [2:0] f_winner(input logic [7:0] v);
    logic [2:0] w = 3'd0;
    for (int k = 0; k < 8; k++) if (v[k]) w = 3'(k);
    return w;
  endfunction

  function automatic logic [7:0] f_opcode(input logic [2:0] n);
    return 8'hC7 | {2'b00, n, 3'b000};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pend = '0; m_reqprev = '0; m_data = '0; m_inta_prev = 1'b1;
    m_intr = 1'b0; m_drive = 1'b0; m_latv = 1'b0; m_lat = '0;
  endtask

  task automatic model_edge(input logic [7:0] rq, input logic ia);
    logic [7:0] rise, clr;
    logic fall, rel;
    rise = rq & ~m_reqprev;
    fall = !ia && m_inta_prev;
    rel  = ia && !m_inta_prev;
    clr  = (rel && m_latv) ? (8'd1 << m_lat) : 8'd0;
    if (fall) begin
      m_lat = f_winner(m_pend); m_latv = |m_pend; m_data = f_opcode(m_lat);
    end else if (ia) begin
      m_data = 8'h00;
    end
    m_pend = (m_pend & ~clr) | rise;
    m_intr = ia & (|m_pend);
    m_drive = !ia;
    m_reqprev = rq;
    m_inta_prev = ia;
  endtask

  // Called at a negative edge: apply inputs, pass one rising edge, check at next negative edge
  task automatic step(input logic [7:0] rq, input logic ia, input string tag);
    req_i = rq; inta_n = ia;
    @(posedge clk);
    if (rst) model_reset(); else model_edge(rq, ia);
    @(negedge clk);
    check({tag, " R5 intr"}, {7'd0, intr_o}, {7'd0, m_intr});
    check({tag, " R3 drive"}, {7'd0, bus_drive_o}, {7'd0, m_drive});
    check({tag, " R2 data"}, bus_data_o, m_data);
  endtask

  initial begin
    model_reset();
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    rst = 1'b1;
    step(8'h00, 1'b1, "R9 reset");
    step(8'h00, 1'b1, "R9 reset");
    check("R9 reset intr", {7'd0, intr_o}, 8'd0);
    check("R9 reset bus", bus_data_o, 8'h00);
    rst = 1'b0;

    // Capture and priority
    step(8'h20, 1'b1, "R4 capture5");
    check("R4 intr after capture", {7'd0, intr_o}, 8'd1);
    step(8'h24, 1'b1, "R4 capture2");
    step(8'h04, 1'b1, "R4 held");
    step(8'h04, 0, "R1 ack");
    check("R1 R2 winner5 EF", bus_data_o, 8'hEF);
    check("R5 intr dropped", {7'd0, intr_o}, 8'd0);
    step(8'h84, 0, "R6 late7");
    check("R6 byte held EF", bus_data_o, 8'hEF);
    step(8'h84, 0, "R6 hold");
    step(8'h84, 1'b1, "R7 release");
    check("R3 released data", bus_data_o, 8'h00);
    check("R7 others keep intr", {7'd0, intr_o}, 8'd1);
    step(8'h84, 0, "R1 ack7");
    check("R2 winner7 FF", bus_data_o, 8'hFF);
    step(8'h84, 1'b1, "R7 release7");
    step(8'h84, 0, "R1 ack2");
    check("R2 winner2 D7", bus_data_o, 8'hD7);
    step(8'h84, 1'b1, "R7 release2");
    check("R4 held lines not recaptured", {7'd0, intr_o}, 8'd0);

    // Empty acknowledge, with a request arriving during it
    step(8'h00, 0, "R8 empty ack");
    check("R8 empty gives C7", bus_data_o, 8'hC7);
    step(8'h01, 0, "R8 new req0");
    step(8'h01, 1'b1, "R8 release");
    check("R8 req0 not cleared", {7'd0, intr_o}, 8'd1);

    // Rising edge on the serviced line at the release edge
    step(8'h00, 1'b1, "R7 drop");
    step(8'h00, 0, "R7 ack0");
    check("R7 winner0 C7", bus_data_o, 8'hC7);
    step(8'h01, 1'b1, "R7 re-raise on release");
    check("R7 new edge kept", {7'd0, intr_o}, 8'd1);

    // Reset in the middle of an acknowledge
    step(8'h41, 0, "R9 pre");
    rst = 1'b1;
    step(8'h41, 0, "R9 mid-ack");
    check("R9 bus released", {7'd0, bus_drive_o}, 8'd0);
    rst = 1'b0;
    step(8'h00, 1'b1, "R9 after");
    check("R9 pending cleared", {7'd0, intr_o}, 8'd0);

    // Random traffic
    begin
      logic [7:0] rq = '0;
      logic ia = 1'b1;
      int hold = 0;
      for (int c = 0; c < 4000; c++) begin
        for (int b = 0; b < 8; b++) if ($urandom_range(0, 9) == 0) rq[b] = ~rq[b];
        if (ia) begin
          if ($urandom_range(0, 5) == 0) begin ia = 1'b0; hold = $urandom_range(1, 4); end
        end else begin
          hold--;
          if (hold <= 0) ia = 1'b1;
        end
        step(rq, ia, "R1 R6 R7 random");
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule